// File: doc/BRIEF.md
# Four-Lane Receive Word Aligner

This block takes four receive byte lanes, each with its own recovered clock, and rebuilds on one shared word clock the 32-bit words that a transmitter sent across the four lanes in parallel. Each lane delivers a decoded byte, a control-character flag and a valid strobe. Each lane writes into its own small dual-clock buffer. On the word-clock side, a controller looks at the head of every buffer. It discards characters until each lane shows the comma character, and measures how many characters separate the earliest lane from the latest.

If the spread fits inside the selected window, the controller declares lock. It then pops all four buffers together, so bytes from one transmitted word leave as one output word. The early lanes simply hold more data in their buffers. A 2-bit setting picks the tolerated skew. While locked, the controller keeps checking that comma characters still arrive on all lanes at once. It drops lock and searches again when they do not.

The alignment only holds when the far end feeds all four lanes from one clock, so that every lane carries characters at the same rate.

Top module: `deskew_rx`

## Requirements
- R1: Lane i's byte appears on word_data[8i+7:8i] and its control flag on word_k[i]. Every presented word carries the four bytes of one transmitted word. While locked, words come out in transmit order with none skipped or repeated.
- R2: depth_sel selects the tolerated spread in 10-bit characters: 2'b01 gives 1, 2'b00 gives 4, 2'b11 gives 9. The reserved code 2'b10 behaves as 1. A spread equal to the window locks, and one character more fails.
- R3: cfg_err is high exactly while depth_sel holds the reserved code 2'b10.
- R4: The comma is a character with its control flag set and byte value 0xBC. Lock is declared when every lane shows a comma at its buffer head and the spread is within the window. Characters ahead of those commas are discarded. The first word presented after aligned rises is the all-comma word, on the clock after the rise.
- R5: When the spread exceeds the window, skew_err pulses for one clock, aligned stays low, all lane buffers are flushed and the search starts over.
- R6: While locked, a word whose lanes carry a comma on some but not all lanes is withheld. skew_err pulses, aligned drops, the buffers are flushed, and alignment is taken again on the next complete set of commas.
- R7: word_valid is never high while aligned is low.
- R8: While rst is high, the next word_clk edge forces aligned, word_valid and skew_err low and empties every lane buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 4 | Recovered clock of each lane |
| rx_byte | input | 32 | Decoded byte of each lane, lane i at bits 8i+7:8i |
| rx_k | input | 4 | Control-character flag of each lane |
| rx_valid | input | 4 | Write strobe of each lane |
| word_clk | input | 1 | Common output word clock |
| rst | input | 1 | Active-high synchronous reset, held for several cycles of every clock |
| depth_sel | input | 2 | Deskew window select |
| word_data | output | 32 | Aligned output word |
| word_k | output | 4 | Control flags of the output bytes |
| word_valid | output | 1 | Output word is valid |
| aligned | output | 1 | Lanes are locked together |
| skew_err | output | 1 | One-clock pulse on an alignment failure |
| cfg_err | output | 1 | Reserved depth code applied |

## Verification
A buffer pointer that is off by one, or a skew count that is off by one, does not stay hidden. It shows up as a word that mixes bytes from two transmit indices. It shows up as an out-of-sequence index on the very next presented word. Or it shows up as a lock, or a failure, on the wrong side of a window boundary. The bench encodes the transmit index and the lane number into every data byte, so each presented word is checked on the clock it appears. Each window is driven exactly at its limit and one character past it. A lost-lock supervisor that is wrong shows within one comma period, when a single stray comma is injected.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

    localparam int LANES_DEF  = 4;
    localparam int BYTE_W_DEF = 8;
    localparam int FIFO_AW_DEF = 4;

    localparam logic [7:0] COMMA_BYTE = 8'hBC;

    // window select codes
    localparam logic [1:0] SEL_MID    = 2'b00;
    localparam logic [1:0] SEL_NARROW = 2'b01;
    localparam logic [1:0] SEL_RSVD   = 2'b10;
    localparam logic [1:0] SEL_WIDE   = 2'b11;

    localparam int WIN_NARROW = 1;
    localparam int WIN_MID    = 4;
    localparam int WIN_WIDE   = 9;
    localparam int WIN_W      = $clog2(WIN_WIDE + 2);

    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } align_st_e;

    function automatic logic [WIN_W-1:0] win_chars(input logic [1:0] sel);
        case (sel)
            SEL_MID:  return WIN_W'(WIN_MID);
            SEL_WIDE: return WIN_W'(WIN_WIDE);
            default:  return WIN_W'(WIN_NARROW);
        endcase
    endfunction

endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              wrst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              rd_en,
    input  logic              flush,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PTR_W = ADDR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
        logic [PTR_W-1:0] sync1;
        logic [PTR_W-1:0] sync2;
    } side_t;

    side_t w_q, w_d, r_q, r_d;
    logic [DATA_W-1:0] mem [DEPTH];
    logic full, wr_ok, rd_ok;

    function automatic logic [PTR_W-1:0] to_gray(input logic [PTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PTR_W-1:0] from_gray(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // write side, lane clock
    assign full  = (w_q.gray == {~w_q.sync2[PTR_W-1:PTR_W-2], w_q.sync2[PTR_W-3:0]});
    assign wr_ok = wr_en && !full;

    always_comb begin
        w_d       = w_q;
        w_d.sync1 = r_q.gray;
        w_d.sync2 = w_q.sync1;
        if (wr_ok) begin
            w_d.bin  = w_q.bin + 1'b1;
            w_d.gray = to_gray(w_d.bin);
        end
    end

    always_ff @(posedge wclk) begin
        if (wrst) w_q <= '0;
        else      w_q <= w_d;
    end

    always_ff @(posedge wclk) begin
        if (wr_ok) mem[w_q.bin[ADDR_W-1:0]] <= wr_data;
    end

    // read side, word clock
    assign empty   = (r_q.gray == r_q.sync2);
    assign rd_ok   = rd_en && !empty;
    assign rd_data = mem[r_q.bin[ADDR_W-1:0]];

    always_comb begin
        r_d       = r_q;
        r_d.sync1 = w_q.gray;
        r_d.sync2 = r_q.sync1;
        if (flush) begin
            r_d.bin  = from_gray(r_q.sync2);
            r_d.gray = r_q.sync2;
        end else if (rd_ok) begin
            r_d.bin  = r_q.bin + 1'b1;
            r_d.gray = to_gray(r_d.bin);
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst) r_q <= '0;
        else      r_q <= r_d;
    end

endmodule

// File: rtl/align_ctrl.sv
module align_ctrl
    import deskew_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [1:0]                    depth_sel,
    input  logic [LANES-1:0][BYTE_W-1:0]  head_byte,
    input  logic [LANES-1:0]              head_k,
    input  logic [LANES-1:0]              head_empty,
    output logic [LANES-1:0]              pop,
    output logic                          flush,
    output logic [LANES*BYTE_W-1:0]       out_word,
    output logic [LANES-1:0]              out_k,
    output logic                          out_valid,
    output logic                          locked,
    output logic                          err
);
    localparam logic [BYTE_W-1:0] K_COMMA = BYTE_W'(COMMA_BYTE);

    typedef struct packed {
        align_st_e                   st;
        logic                        armed;
        logic [WIN_W-1:0]            cnt;
        logic                        vld;
        logic [LANES-1:0][BYTE_W-1:0] word;
        logic [LANES-1:0]            kf;
        logic                        err;
    } ctl_t;

    ctl_t q, d;
    logic [LANES-1:0] is_comma;
    logic [WIN_W-1:0] win;
    logic [WIN_W-1:0] skew_now;

    for (genvar g = 0; g < LANES; g++) begin : g_comma
        assign is_comma[g] = !head_empty[g] && head_k[g] && (head_byte[g] == K_COMMA);
    end

    assign win      = win_chars(depth_sel);
    assign skew_now = q.armed ? q.cnt + 1'b1 : '0;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.err = 1'b0;
        pop   = '0;
        flush = 1'b0;
        case (q.st)
            ST_SEARCH: begin
                if (&is_comma) begin
                    d.armed = 1'b0;
                    d.cnt   = '0;
                    if (skew_now <= win) begin
                        d.st = ST_LOCKED;
                    end else begin
                        d.err = 1'b1;
                        flush = 1'b1;
                    end
                end else if (|is_comma) begin
                    if (skew_now > win) begin
                        d.err   = 1'b1;
                        d.armed = 1'b0;
                        d.cnt   = '0;
                        flush   = 1'b1;
                    end else begin
                        d.armed = 1'b1;
                        d.cnt   = skew_now;
                        pop     = ~is_comma & ~head_empty;
                    end
                end else begin
                    pop = ~head_empty;
                end
            end
            ST_LOCKED: begin
                if (!(|head_empty)) begin
                    if ((|is_comma) && !(&is_comma)) begin
                        d.st  = ST_SEARCH;
                        d.err = 1'b1;
                        flush = 1'b1;
                    end else begin
                        pop    = '1;
                        d.vld  = 1'b1;
                        d.word = head_byte;
                        d.kf   = head_k;
                    end
                end
            end
            default: d.st = ST_SEARCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign out_word  = q.word;
    assign out_k     = q.kf;
    assign out_valid = q.vld;
    assign locked    = (q.st == ST_LOCKED);
    assign err       = q.err;

endmodule

// File: rtl/deskew_rx.sv
module deskew_rx
    import deskew_pkg::*;
#(
    parameter int LANES   = LANES_DEF,
    parameter int BYTE_W  = BYTE_W_DEF,
    parameter int FIFO_AW = FIFO_AW_DEF
) (
    input  logic [LANES-1:0]        rx_clk,
    input  logic [LANES*BYTE_W-1:0] rx_byte,
    input  logic [LANES-1:0]        rx_k,
    input  logic [LANES-1:0]        rx_valid,
    input  logic                    word_clk,
    input  logic                    rst,
    input  logic [1:0]              depth_sel,
    output logic [LANES*BYTE_W-1:0] word_data,
    output logic [LANES-1:0]        word_k,
    output logic                    word_valid,
    output logic                    aligned,
    output logic                    skew_err,
    output logic                    cfg_err
);
    localparam int CHAR_W = BYTE_W + 1;

    logic [LANES-1:0][CHAR_W-1:0] head;
    logic [LANES-1:0][BYTE_W-1:0] head_byte;
    logic [LANES-1:0]             head_k;
    logic [LANES-1:0]             head_empty;
    logic [LANES-1:0]             pop;
    logic                         flush;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_fifo #(
            .DATA_W (CHAR_W),
            .ADDR_W (FIFO_AW)
        ) u_fifo (
            .wclk    (rx_clk[g]),
            .wrst    (rst),
            .wr_en   (rx_valid[g]),
            .wr_data ({rx_k[g], rx_byte[g*BYTE_W +: BYTE_W]}),
            .rclk    (word_clk),
            .rrst    (rst),
            .rd_en   (pop[g]),
            .flush   (flush),
            .rd_data (head[g]),
            .empty   (head_empty[g])
        );
        assign head_byte[g] = head[g][BYTE_W-1:0];
        assign head_k[g]    = head[g][CHAR_W-1];
    end

    align_ctrl #(
        .LANES  (LANES),
        .BYTE_W (BYTE_W)
    ) u_ctrl (
        .clk        (word_clk),
        .rst        (rst),
        .depth_sel  (depth_sel),
        .head_byte  (head_byte),
        .head_k     (head_k),
        .head_empty (head_empty),
        .pop        (pop),
        .flush      (flush),
        .out_word   (word_data),
        .out_k      (word_k),
        .out_valid  (word_valid),
        .locked     (aligned),
        .err        (skew_err)
    );

    assign cfg_err = (depth_sel == SEL_RSVD);

endmodule

// File: rtl/deskew_rx_chk.sv
module deskew_rx_chk
    import deskew_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    word_valid,
    input logic [LANES*BYTE_W-1:0] word_data,
    input logic [LANES-1:0]        word_k,
    input logic                    aligned,
    input logic                    skew_err
);
    localparam logic [BYTE_W-1:0] K_COMMA = BYTE_W'(COMMA_BYTE);

    logic [LANES-1:0] comma_vec;

    for (genvar g = 0; g < LANES; g++) begin : g_cv
        assign comma_vec[g] = word_k[g] && (word_data[g*BYTE_W +: BYTE_W] == K_COMMA);
    end

    AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> aligned); // R7

    AST_WORD_UNMIXED: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> ($countones(comma_vec) == 0 || $countones(comma_vec) == LANES)); // R1

    AST_ERR_NOT_LOCKED: assert property (@(posedge clk) disable iff (rst)
        skew_err |-> !aligned); // R5

    AST_FIRST_IS_COMMA: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned) |=> (word_valid && (&comma_vec))); // R4

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!aligned && !word_valid && !skew_err)); // R8

endmodule

bind deskew_rx deskew_rx_chk #(
    .LANES  (LANES),
    .BYTE_W (BYTE_W)
) i_chk (
    .clk        (word_clk),
    .rst        (rst),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_k     (word_k),
    .aligned    (aligned),
    .skew_err   (skew_err)
);

// File: tb/test_deskew_rx.sv
module test_deskew_rx;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  sel = 2'b00;
    logic [31:0] rx_byte = '0;
    logic [3:0]  rx_k = '0;
    logic [3:0]  rx_valid = 4'hF;
    logic [31:0] word_data;
    logic [3:0]  word_k;
    logic        word_valid, aligned, skew_err, cfg_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    deskew_rx i_deskew_rx (
        .rx_clk     ({NL{clk}}),
        .rx_byte    (rx_byte),
        .rx_k       (rx_k),
        .rx_valid   (rx_valid),
        .word_clk   (clk),
        .rst        (rst),
        .depth_sel  (sel),
        .word_data  (word_data),
        .word_k     (word_k),
        .word_valid (word_valid),
        .aligned    (aligned),
        .skew_err   (skew_err),
        .cfg_err    (cfg_err)
    );

    int errors = 0;
    int checks = 0;
    int cyc;
    int skew [NL];
    bit corrupt_on;
    int corrupt_n = 52;

    bit need_comma, after_comma, aligned_prev;
    int prev_n, lock_rises, err_seen, words_seen;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // lane l at cycle cyc sends transmit word cyc-skew[l]; comma word when n%32==8
    task automatic drive_lanes();
        for (int l = 0; l < NL; l++) begin
            int n;
            n = cyc - skew[l];
            if (n < 0) begin
                rx_k[l] = 1'b0; rx_byte[l*8 +: 8] = 8'hFF;
            end else if ((corrupt_on && l == 2 && n == corrupt_n) || (n % 32 == 8)) begin
                rx_k[l] = 1'b1; rx_byte[l*8 +: 8] = 8'hBC;
            end else begin
                rx_k[l] = 1'b0; rx_byte[l*8 +: 8] = 8'((n * 4 + l) & 255);
            end
        end
    endtask

    task automatic monitor();
        if (word_valid && !aligned) check(1'b0, "R7 valid without lock", 1, 0);
        if (skew_err) begin err_seen++; need_comma = 1'b1; end
        if (aligned && !aligned_prev) begin lock_rises++; need_comma = 1'b1; end
        aligned_prev = aligned;
        if (word_valid) begin
            bit allc;
            words_seen++;
            allc = (word_k == 4'hF) && (word_data == 32'hBCBCBCBC);
            if (need_comma) begin
                check(allc, "R4 first word is comma", int'(word_data), 32'hBCBCBCBC);
                need_comma = 1'b0; after_comma = 1'b1;
            end else if (allc) begin
                check(((prev_n + 1) % 32) == 8, "R1 comma in sequence", (prev_n + 1) % 32, 8);
                prev_n = (prev_n + 1) % 64; after_comma = 1'b1;
            end else begin
                int n;
                bit same;
                n = int'(word_data[7:2]);
                same = (word_k == 4'h0);
                for (int l = 0; l < NL; l++)
                    if (word_data[l*8 +: 8] != 8'((n * 4 + l) & 255)) same = 1'b0;
                check(same, "R1 bytes from one word", int'(word_data), n);
                if (after_comma) check((n % 32) == 9, "R1 index after comma", n % 32, 9);
                else check(n == (prev_n + 1) % 64, "R1 index order", n, (prev_n + 1) % 64);
                prev_n = n; after_comma = 1'b0;
            end
        end
    endtask

    task automatic run_case(input logic [1:0] s, input int a, input int b, input int c,
                            input int d, input int ncyc, input bit corr);
        sel = s; skew[0] = a; skew[1] = b; skew[2] = c; skew[3] = d;
        corrupt_on = corr; rst = 1'b1; cyc = -20;
        repeat (4) begin @(negedge clk); drive_lanes(); end
        check(!aligned && !word_valid && !skew_err, "R8 reset outputs",
              {aligned, word_valid, skew_err}, 0);
        need_comma = 1'b1; after_comma = 1'b0; aligned_prev = 1'b0; prev_n = 0;
        lock_rises = 0; err_seen = 0; words_seen = 0;
        rst = 1'b0; cyc = 0;
        for (int k = 0; k < ncyc; k++) begin
            drive_lanes();
            @(negedge clk);
            monitor();
            cyc++;
        end
    endtask

    initial begin
        // R2 R4: window 4, spread exactly 4
        run_case(2'b00, 0, 2, 4, 1, 200, 1'b0);
        check(lock_rises == 1, "R4 lock at window limit", lock_rises, 1);
        check(err_seen == 0, "R2 no error inside window", err_seen, 0);
        check(words_seen > 150, "R1 stream flows", words_seen, 151);
        check(cfg_err == 1'b0, "R3 cfg_err low for valid code", cfg_err, 0);
        // R5: window 4, spread 5
        run_case(2'b00, 0, 5, 0, 0, 300, 1'b0);
        check(lock_rises == 0, "R5 no lock beyond window", lock_rises, 0);
        check(err_seen > 0, "R5 skew_err raised", err_seen, 1);
        check(words_seen == 0, "R7 nothing presented", words_seen, 0);
        // R2: narrow window
        run_case(2'b01, 0, 1, 1, 0, 200, 1'b0);
        check(lock_rises == 1 && err_seen == 0, "R2 narrow locks at 1", lock_rises, 1);
        run_case(2'b01, 0, 2, 0, 0, 200, 1'b0);
        check(lock_rises == 0 && err_seen > 0, "R2 narrow fails at 2", lock_rises, 0);
        // R2: wide window
        run_case(2'b11, 9, 0, 3, 0, 200, 1'b0);
        check(lock_rises == 1 && err_seen == 0, "R2 wide locks at 9", lock_rises, 1);
        check(words_seen > 100, "R1 wide stream flows", words_seen, 101);
        run_case(2'b11, 10, 0, 0, 0, 200, 1'b0);
        check(lock_rises == 0 && err_seen > 0, "R2 wide fails at 10", lock_rises, 0);
        // R3 R2: reserved code acts as narrow
        run_case(2'b10, 0, 2, 0, 0, 200, 1'b0);
        check(cfg_err == 1'b1, "R3 cfg_err on reserved code", cfg_err, 1);
        check(lock_rises == 0 && err_seen > 0, "R2 reserved fails at 2", lock_rises, 0);
        run_case(2'b10, 1, 0, 0, 0, 200, 1'b0);
        check(lock_rises == 1 && err_seen == 0, "R2 reserved locks at 1", lock_rises, 1);
        // R6: stray comma on one lane while locked
        run_case(2'b00, 1, 0, 3, 2, 300, 1'b1);
        check(err_seen == 1, "R6 one error on stray comma", err_seen, 1);
        check(lock_rises == 2, "R6 relock after stray comma", lock_rises, 2);
        check(words_seen > 150, "R6 stream resumes", words_seen, 151);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule